// File: doc/BRIEF.md
# Translation Cache with Most-Recently-Used Ordering

This block is a small, fully associative cache of address translations. Each slot holds a virtual page number and the physical frame it maps to. It also holds a set of tags that decide when the slot may answer: an address-space ID, a virtual-machine ID, a hypervisor flag, a non-secure flag, a global flag and an exception-level tag. A lookup compares all slots at once. The lowest-numbered matching slot answers, and a registered response follows one cycle later. The slots are kept in recency order. A hit moves the matching slot to slot 0, and a new translation always enters at slot 0 and pushes the oldest one out of the array.

Invalidation is done by a sequential scan that takes one cycle per slot. There are four selection kinds, and each kind is further narrowed by security state, virtual-machine ID and target exception level. While a scan runs, the block ignores lookups and inserts. It raises a one-cycle done pulse when the scan ends and keeps a saturating count of every slot it has cleared.

Top module: `tlb_mru`

## Requirements
- R1: After reset every slot is invalid, `busy`, `fl_done` and `rsp_valid` are 0 and `flushed_count` is 0, so any lookup misses.
- R2: A lookup accepted at a clock edge produces `rsp_valid`=1 after that same edge, for one cycle. `rsp_hit` is 1 only when a valid slot matches on all of the following: the page number, the VM ID, the hyp flag, a non-secure tag equal to the inverse of `lk_secure`, the exception-level rule and the ASID rule. `rsp_pfn` gives that slot's frame number on a hit and 0 on a miss.
- R3: When several slots match, the one with the lowest index answers.
- R4: A hit moves the matching slot to index 0. The slots that stood in front of it each move back by one place, and the slots behind it keep their places.
- R5: An insert writes the new translation to index 0 with its valid bit set and shifts every other slot back by one place. The slot at the last index is dropped.
- R6: The ASID rule holds when the slot ASID equals the lookup ASID, when the slot is global, or when `lk_any_asid` is 1.
- R7: The exception-level rule works as follows. For a target level of 2 or 3, the slot level must equal the target. For a target level of 0 or 1, a slot at level 0 or 1 matches.
- R8: A scan clears a slot only if all of these hold: the slot is valid, its non-secure tag is the inverse of `fl_secure`, its VM ID equals `fl_vmid` (this condition is waived when `fl_secure` is 1), and the R7 rule holds with `fl_el` as the target.
- R9: `fl_kind` narrows the R8 set as follows. 0 clears every qualifying slot. 1 also requires the ASID to equal `fl_asid`. 2 also requires the page to equal `fl_vpn` and the ASID to equal `fl_asid` or the slot to be global. 3 also requires the page to equal `fl_vpn`, whatever the ASID.
- R10: A flush request is accepted at an edge while idle. `busy` is then 1 for ENTRIES cycles and falls together with a one-cycle `fl_done` pulse. Lookups and inserts made while `busy` is 1 are dropped. A flush request takes priority over an insert, and an insert takes priority over a lookup, in the same cycle.
- R11: `flushed_count` grows by one for each slot a scan clears and holds at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_vmid | input | VMID_W | Lookup VM ID |
| lk_hyp | input | 1 | Lookup hyp flag |
| lk_secure | input | 1 | Lookup is in secure state |
| lk_any_asid | input | 1 | Skip the ASID compare |
| lk_el | input | EL_W | Lookup target exception level |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | New page number |
| ins_pfn | input | PFN_W | New frame number |
| ins_asid | input | ASID_W | New ASID |
| ins_vmid | input | VMID_W | New VM ID |
| ins_hyp | input | 1 | New hyp flag |
| ins_ns | input | 1 | New non-secure tag |
| ins_global | input | 1 | New global flag |
| ins_el | input | EL_W | New exception-level tag |
| fl_valid | input | 1 | Flush request |
| fl_kind | input | 2 | Flush selection kind (R9) |
| fl_vpn | input | VPN_W | Flush page number |
| fl_asid | input | ASID_W | Flush ASID |
| fl_vmid | input | VMID_W | Flush VM ID |
| fl_secure | input | 1 | Flush is in secure state |
| fl_el | input | EL_W | Flush target exception level |
| busy | output | 1 | Scan in progress |
| fl_done | output | 1 | One-cycle pulse at the end of a scan |
| flushed_count | output | CNT_W | Saturating count of cleared slots |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number on a hit, else 0 |

## Verification
A lookup's response appears right after the edge that accepts it. Each lookup check therefore drives the request on a falling edge and reads the result on the next falling edge. Reordering and insert eviction take effect at the same edge, so the next lookup already sees the new order. After a flush is accepted, the bench counts exactly ENTRIES falling edges with `busy` high and `fl_done` low, and expects `fl_done` high and `busy` low on the one after; the count is read in that same sample. Lookups held during the scan are checked for a missing `rsp_valid` at every one of those samples.

// File: rtl/tlb_mru_pkg.sv
package tlb_mru_pkg;
  parameter int VPN_W  = 20;
  parameter int PFN_W  = 20;
  parameter int ASID_W = 8;
  parameter int VMID_W = 8;
  parameter int EL_W   = 2;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              hyp;
    logic              ns;
    logic              glob;
    logic [EL_W-1:0]   el;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_ASID    = 2'd1,
    FL_VA_ASID = 2'd2,
    FL_VA      = 2'd3
  } fl_kind_t;

  typedef struct packed {
    fl_kind_t          kind;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              secure;
    logic [EL_W-1:0]   el;
  } fl_cmd_t;

  // Level rule: levels 2/3 need an exact match, lower targets accept 0 or 1.
  function automatic logic el_hit(input logic [EL_W-1:0] tgt,
                                  input logic [EL_W-1:0] tag);
    if (tgt >= EL_W'(2)) return tag == tgt;
    else                 return tag <= EL_W'(1);
  endfunction

  function automatic logic flush_hit(input tlb_ent_t e, input fl_cmd_t c);
    logic q;
    q = e.valid && (e.ns == !c.secure) && ((e.vmid == c.vmid) || c.secure)
        && el_hit(c.el, e.el);
    case (c.kind)
      FL_ALL:     return q;
      FL_ASID:    return q && (e.asid == c.asid);
      FL_VA_ASID: return q && (e.vpn == c.vpn) && ((e.asid == c.asid) || e.glob);
      default:    return q && (e.vpn == c.vpn);
    endcase
  endfunction
endpackage

// File: rtl/tlb_mru_match.sv
module tlb_mru_match
  import tlb_mru_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  tlb_ent_t          ents [ENTRIES],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  input  logic [VMID_W-1:0] vmid,
  input  logic              hyp,
  input  logic              secure,
  input  logic              any_asid,
  input  logic [EL_W-1:0]   el,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [PFN_W-1:0]  pfn
);
  logic [ENTRIES-1:0] m;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign m[g] = ents[g].valid && (ents[g].vpn == vpn) && (ents[g].vmid == vmid)
                  && (ents[g].hyp == hyp) && (ents[g].ns == !secure)
                  && el_hit(el, ents[g].el)
                  && (any_asid || ents[g].glob || (ents[g].asid == asid));
  end

  // Descending walk so the lowest matching index is the one kept.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        pfn = ents[i].pfn;
      end
    end
  end
endmodule

// File: rtl/tlb_mru_store.sv
module tlb_mru_store
  import tlb_mru_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  tlb_ent_t         ins_ent,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output tlb_ent_t         ents [ENTRIES]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
    end else if (ins_en) begin
      ents[0] <= ins_ent;
      for (int i = 1; i < ENTRIES; i++) ents[i] <= ents[i-1];
    end else if (hit_en) begin
      ents[0] <= ents[hit_idx];
      for (int i = 1; i < ENTRIES; i++)
        if (IDX_W'(i) <= hit_idx) ents[i] <= ents[i-1];
    end else if (clr_en) begin
      ents[clr_idx].valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_mru_flush.sv
module tlb_mru_flush
  import tlb_mru_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  fl_cmd_t          cmd_in,
  input  logic             cur_hit,
  output fl_cmd_t          cmd,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             clr,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  assign clr = busy && cur_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      done  <= 1'b0;
      count <= '0;
      cmd   <= '0;
    end else begin
      done <= 1'b0;
      if (clr && (count != {CNT_W{1'b1}})) count <= count + 1'b1;
      if (start && !busy) begin
        cmd  <= cmd_in;
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_mru.sv
module tlb_mru
  import tlb_mru_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              lk_hyp,
  input  logic              lk_secure,
  input  logic              lk_any_asid,
  input  logic [EL_W-1:0]   lk_el,
  input  logic              ins_valid,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PFN_W-1:0]  ins_pfn,
  input  logic [ASID_W-1:0] ins_asid,
  input  logic [VMID_W-1:0] ins_vmid,
  input  logic              ins_hyp,
  input  logic              ins_ns,
  input  logic              ins_global,
  input  logic [EL_W-1:0]   ins_el,
  input  logic              fl_valid,
  input  logic [1:0]        fl_kind,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VMID_W-1:0] fl_vmid,
  input  logic              fl_secure,
  input  logic [EL_W-1:0]   fl_el,
  output logic              busy,
  output logic              fl_done,
  output logic [CNT_W-1:0]  flushed_count,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn
);
  tlb_ent_t         ents [ENTRIES];
  tlb_ent_t         new_ent;
  fl_cmd_t          cmd_in, cmd;
  logic             fl_go, ins_go, lk_go;
  logic             m_hit;
  logic [IDX_W-1:0] m_idx, f_idx;
  logic [PFN_W-1:0] m_pfn;
  logic             f_clr, f_cur_hit;

  // One operation per cycle: flush, then insert, then lookup.
  assign fl_go  = fl_valid && !busy;
  assign ins_go = ins_valid && !busy && !fl_valid;
  assign lk_go  = lk_valid && !busy && !fl_valid && !ins_valid;

  assign new_ent = '{valid: 1'b1, vpn: ins_vpn, pfn: ins_pfn, asid: ins_asid,
                     vmid: ins_vmid, hyp: ins_hyp, ns: ins_ns, glob: ins_global,
                     el: ins_el};
  assign cmd_in  = '{kind: fl_kind_t'(fl_kind), vpn: fl_vpn, asid: fl_asid,
                     vmid: fl_vmid, secure: fl_secure, el: fl_el};
  assign f_cur_hit = flush_hit(ents[f_idx], cmd);

  tlb_mru_match #(.ENTRIES(ENTRIES)) u_match (
    .ents(ents), .vpn(lk_vpn), .asid(lk_asid), .vmid(lk_vmid), .hyp(lk_hyp),
    .secure(lk_secure), .any_asid(lk_any_asid), .el(lk_el),
    .hit(m_hit), .idx(m_idx), .pfn(m_pfn)
  );

  tlb_mru_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .ins_en(ins_go), .ins_ent(new_ent),
    .hit_en(lk_go && m_hit), .hit_idx(m_idx),
    .clr_en(f_clr), .clr_idx(f_idx), .ents(ents)
  );

  tlb_mru_flush #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_flush (
    .clk(clk), .rst(rst), .start(fl_go), .cmd_in(cmd_in), .cur_hit(f_cur_hit),
    .cmd(cmd), .busy(busy), .idx(f_idx), .clr(f_clr), .done(fl_done),
    .count(flushed_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_valid <= lk_go;
      rsp_hit   <= lk_go && m_hit;
      rsp_pfn   <= (lk_go && m_hit) ? m_pfn : '0;
    end
  end
endmodule

// File: rtl/tlb_mru_chk.sv
module tlb_mru_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             fl_valid,
  input logic             busy,
  input logic             fl_done,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] flushed_count
);
  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lk_valid));
  a_r2_hit_has_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  a_r10_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> fl_done);
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    fl_done |=> !fl_done);
  a_r10_busy_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(fl_valid));
  a_r10_no_rsp_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rsp_valid);
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
    flushed_count >= $past(flushed_count));
endmodule

bind tlb_mru tlb_mru_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .fl_valid(fl_valid), .busy(busy),
  .fl_done(fl_done), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .flushed_count(flushed_count)
);

// File: tb/sim_tlb_mru.sv
`timescale 1ns/1ps
module sim_tlb_mru;
  import tlb_mru_pkg::*;
  localparam int N = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, lk_hyp = 0, lk_secure = 0, lk_any_asid = 0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [VMID_W-1:0] lk_vmid = '0;
  logic [EL_W-1:0] lk_el = '0;
  logic ins_valid = 0, ins_hyp = 0, ins_ns = 0, ins_global = 0;
  logic [VPN_W-1:0] ins_vpn = '0;
  logic [PFN_W-1:0] ins_pfn = '0;
  logic [ASID_W-1:0] ins_asid = '0;
  logic [VMID_W-1:0] ins_vmid = '0;
  logic [EL_W-1:0] ins_el = '0;
  logic fl_valid = 0, fl_secure = 0;
  logic [1:0] fl_kind = '0;
  logic [VPN_W-1:0] fl_vpn = '0;
  logic [ASID_W-1:0] fl_asid = '0;
  logic [VMID_W-1:0] fl_vmid = '0;
  logic [EL_W-1:0] fl_el = '0;
  logic busy, fl_done, rsp_valid, rsp_hit;
  logic [15:0] flushed_count;
  logic [PFN_W-1:0] rsp_pfn;

  int n_chk = 0, n_fail = 0, exp_cnt = 0;

  always #2.5 clk = ~clk;

  tlb_mru #(.ENTRIES(N), .CNT_W(16)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    exp_cnt = 0;
  endtask

  task automatic ins(input int vpn, pfn, asid, vmid, input bit hyp, ns, glob, input int el);
    @(negedge clk);
    ins_valid = 1; ins_vpn = VPN_W'(vpn); ins_pfn = PFN_W'(pfn); ins_asid = ASID_W'(asid);
    ins_vmid = VMID_W'(vmid); ins_hyp = hyp; ins_ns = ns; ins_global = glob; ins_el = EL_W'(el);
    @(negedge clk); ins_valid = 0;
  endtask

  task automatic look(input int vpn, asid, vmid, input bit hyp, sec, any, input int el,
                      input bit exp_hit, input int exp_pfn, input string req);
    @(negedge clk);
    lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_vmid = VMID_W'(vmid);
    lk_hyp = hyp; lk_secure = sec; lk_any_asid = any; lk_el = EL_W'(el);
    @(negedge clk); lk_valid = 0;
    chk(rsp_valid == 1'b1 && rsp_hit == exp_hit && rsp_pfn == PFN_W'(exp_hit ? exp_pfn : 0),
        req, {rsp_valid, rsp_hit, 4'h0, 32'(rsp_pfn)},
        {1'b1, exp_hit, 4'h0, 32'(exp_hit ? exp_pfn : 0)});
  endtask

  // R10 timing, R11 count; optional stall of lookups/inserts during the scan.
  task automatic flush(input int kind, vpn, asid, vmid, input bit sec, input int el,
                       input int n_clear, input bit stall);
    @(negedge clk);
    fl_valid = 1; fl_kind = 2'(kind); fl_vpn = VPN_W'(vpn); fl_asid = ASID_W'(asid);
    fl_vmid = VMID_W'(vmid); fl_secure = sec; fl_el = EL_W'(el);
    @(negedge clk); fl_valid = 0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (stall) begin
      lk_valid = 1; lk_vpn = VPN_W'('h700); lk_vmid = 1; lk_secure = 0; lk_el = 0; lk_any_asid = 1;
      ins_valid = 1; ins_vpn = VPN_W'('h700); ins_pfn = 'h777; ins_vmid = 1; ins_ns = 1; ins_el = 0;
    end
    for (int c = 1; c < N; c++) begin
      @(negedge clk);
      chk(busy == 1'b1 && fl_done == 1'b0, "R10 busy during scan", {busy, fl_done}, 2);
      if (stall) chk(rsp_valid == 1'b0, "R10 lookup dropped while busy", rsp_valid, 0);
    end
    @(negedge clk);
    lk_valid = 0; ins_valid = 0;
    chk(busy == 1'b0 && fl_done == 1'b1, "R10 done pulse at end", {busy, fl_done}, 1);
    if (stall) chk(rsp_valid == 1'b0, "R10 lookup dropped at last scan cycle", rsp_valid, 0);
    exp_cnt += n_clear;
    chk(flushed_count == 16'(exp_cnt), "R11 cleared count", flushed_count, exp_cnt);
    @(negedge clk);
    chk(fl_done == 1'b0, "R10 done lasts one cycle", fl_done, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && fl_done == 0 && rsp_valid == 0 && flushed_count == 0,
        "R1 reset outputs", {busy, fl_done, rsp_valid, 4'h0, flushed_count}, 0);
    look('h100, 5, 1, 0, 0, 0, 0, 0, 0, "R1 empty after reset");
  endtask

  task automatic t_basic();
    ins('h100, 'hA00, 5, 1, 0, 1, 0, 0);
    look('h100, 5, 1, 0, 0, 0, 0, 1, 'hA00, "R2 hit");
    look('h101, 5, 1, 0, 0, 0, 0, 0, 0, "R2 page mismatch");
    look('h100, 5, 1, 1, 0, 0, 0, 0, 0, "R2 hyp mismatch");
    look('h100, 5, 2, 0, 0, 0, 0, 0, 0, "R2 vmid mismatch");
    look('h100, 5, 1, 0, 1, 0, 0, 0, 0, "R2 security mismatch");
  endtask

  task automatic t_asid();
    look('h100, 6, 1, 0, 0, 0, 0, 0, 0, "R6 asid mismatch");
    look('h100, 6, 1, 0, 0, 1, 0, 1, 'hA00, "R6 any-asid lookup");
    ins('h200, 'hB00, 9, 1, 0, 1, 1, 0);
    look('h200, 3, 1, 0, 0, 0, 0, 1, 'hB00, "R6 global any asid");
  endtask

  task automatic t_el();
    ins('h300, 'hC00, 5, 1, 0, 1, 0, 1);
    look('h300, 5, 1, 0, 0, 0, 0, 1, 'hC00, "R7 target 0 vs level 1");
    look('h300, 5, 1, 0, 0, 0, 1, 1, 'hC00, "R7 target 1 vs level 1");
    look('h300, 5, 1, 0, 0, 0, 2, 0, 0, "R7 target 2 vs level 1");
    ins('h301, 'hC01, 5, 1, 0, 1, 0, 2);
    look('h301, 5, 1, 0, 0, 0, 2, 1, 'hC01, "R7 target 2 exact");
    look('h301, 5, 1, 0, 0, 0, 3, 0, 0, "R7 target 3 vs level 2");
    look('h301, 5, 1, 0, 0, 0, 0, 0, 0, "R7 target 0 vs level 2");
  endtask

  task automatic t_first();
    ins('h400, 'hD00, 5, 1, 0, 1, 0, 0);
    ins('h400, 'hD01, 5, 1, 0, 1, 0, 0);
    look('h400, 5, 1, 0, 0, 0, 0, 1, 'hD01, "R3 lowest index wins");
  endtask

  task automatic t_mru();
    do_reset();
    for (int i = 0; i < N; i++) ins('h500 + i, 'hE00 + i, 5, 1, 0, 1, 0, 0);
    look('h500, 5, 1, 0, 0, 0, 0, 1, 'hE00, "R4 hit on last slot");
    ins('h510, 'hE10, 5, 1, 0, 1, 0, 0);
    look('h501, 5, 1, 0, 0, 0, 0, 0, 0, "R5 oldest evicted");
    look('h500, 5, 1, 0, 0, 0, 0, 1, 'hE00, "R4 moved slot survives");
    look('h510, 5, 1, 0, 0, 0, 0, 1, 'hE10, "R5 new slot present");
  endtask

  task automatic t_flush();
    do_reset();
    ins('h600, 'hF00, 1, 1, 0, 1, 0, 0);
    ins('h601, 'hF01, 2, 1, 0, 1, 0, 0);
    ins('h602, 'hF02, 1, 2, 0, 1, 0, 0);
    ins('h603, 'hF03, 1, 1, 0, 0, 0, 0);
    ins('h604, 'hF04, 1, 1, 0, 1, 0, 2);
    ins('h605, 'hF05, 3, 1, 0, 1, 1, 0);
    flush(1, 0, 1, 1, 0, 0, 1, 0);
    look('h600, 1, 1, 0, 0, 0, 0, 0, 0, "R9 asid flush clears");
    look('h601, 2, 1, 0, 0, 0, 0, 1, 'hF01, "R9 other asid kept");
    look('h602, 1, 2, 0, 0, 0, 0, 1, 'hF02, "R8 other vmid kept");
    look('h603, 1, 1, 0, 1, 0, 0, 1, 'hF03, "R8 secure slot kept");
    look('h604, 1, 1, 0, 0, 0, 2, 1, 'hF04, "R8 level 2 slot kept");
    look('h605, 3, 1, 0, 0, 0, 0, 1, 'hF05, "R9 global kept by asid flush");
    flush(2, 'h605, 7, 1, 0, 1, 1, 0);
    look('h605, 3, 1, 0, 0, 0, 0, 0, 0, "R9 page+asid flush takes global");
    flush(3, 'h601, 0, 1, 0, 0, 1, 0);
    look('h601, 2, 1, 0, 0, 0, 0, 0, 0, "R9 page flush any asid");
    flush(0, 0, 0, 9, 1, 0, 1, 0);
    look('h603, 1, 1, 0, 1, 0, 0, 0, 0, "R8 secure flush ignores vmid");
    look('h602, 1, 2, 0, 0, 0, 0, 1, 'hF02, "R8 secure flush keeps non-secure");
    flush(0, 0, 0, 1, 0, 2, 1, 0);
    look('h604, 1, 1, 0, 0, 0, 2, 0, 0, "R8 level 2 flush");
    look('h602, 1, 2, 0, 0, 0, 0, 1, 'hF02, "R8 vmid 2 still kept");
    flush(0, 0, 0, 2, 0, 0, 1, 1);
    look('h602, 1, 2, 0, 0, 0, 0, 0, 0, "R9 flush all vmid 2");
    look('h700, 0, 1, 0, 0, 1, 0, 0, 0, "R10 insert dropped while busy");
  endtask

  task automatic t_prio();
    @(negedge clk);
    ins_valid = 1; ins_vpn = 'h800; ins_pfn = 'h880; ins_asid = 0; ins_vmid = 1;
    ins_ns = 1; ins_global = 0; ins_el = 0; ins_hyp = 0;
    lk_valid = 1; lk_vpn = 'h800; lk_vmid = 1; lk_asid = 0; lk_any_asid = 0;
    lk_secure = 0; lk_el = 0; lk_hyp = 0;
    @(negedge clk); ins_valid = 0; lk_valid = 0;
    chk(rsp_valid == 1'b0, "R10 insert beats lookup", rsp_valid, 0);
    look('h800, 0, 1, 0, 0, 0, 0, 1, 'h880, "R10 insert taken");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_asid();
    t_el();
    t_first();
    t_mru();
    t_flush();
    t_prio();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule